// File: doc/BRIEF.md
# Peripheral Clock Request Arbiter

This block decides which of four peripheral clock outputs are switched on. Each peripheral drives its own request pin. The pin is first synchronized into the logic clock domain. It is then qualified by a per-channel sense bit and by two per-channel override bits, and the result is a registered enable for that channel's clock gate.

The qualified requests are also combined into a single request toward the upstream clock source. That output has a selectable active level. It can also be driven in an open style, where it is driven only while asserted and released otherwise. This allows an external pull resistor to set the idle level.

A two-bit mode field decides whether the supply regulator follows the combined request, stays on, or stays off. A thermal-fault flag forces every enable low and the request inactive. The status view of the requests stays live during the fault so that register logic can still report it.

Top module: `clkreq_arbiter`

## Requirements
- R1: For each channel, with its sense bit at 1 a high synchronized pin requests the clock, and with the sense bit at 0 a low pin requests it. The channel enable (bit i of `ch_enable`) follows the qualified request.
- R2: A set force-off bit drives that channel's request and enable to 0, whatever the pin and the force-on bit are.
- R3: A set force-on bit with force-off clear drives that channel's request to 1, whatever the pin is.
- R4: The combined request is asserted when any qualified channel request is 1, or when `sreq_force` is 1.
- R5: With `sreq_active_high` at 1, `sreq_level` equals the asserted state; with it at 0, `sreq_level` is its inverse.
- R6: With `sreq_open` at 0, `sreq_drive_en` is 1 at all times outside reset. With `sreq_open` at 1, `sreq_drive_en` is 1 only while the combined request is asserted.
- R7: Regulator mode 2'b00 and the reserved code 2'b01 keep `reg_enable` at 0. Mode 2'b10 sets it to 1 when any qualified channel request is 1; `sreq_force` does not count here. Mode 2'b11 holds it at 1.
- R8: While `thermal_fault` is 1, `ch_enable` is 0, `reg_enable` is 0 and the combined request is deasserted, driven at its inactive level. `stat_ch_req` still shows the qualified requests.
- R9: `stat_ch_req` reports the qualified per-channel requests. `stat_sreq` is 1 exactly when the combined request is asserted.
- R10: A pin change reaches the outputs on the third rising clock edge after it (two synchronizer stages and one output register). A configuration change reaches them on the first edge.
- R11: A synchronous reset sets every output and both synchronizer stages to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin | input | NCH | Raw asynchronous request pins |
| ch_active_high | input | NCH | Per-channel sense: 1 = high requests |
| ch_force_on | input | NCH | Per-channel force-on override |
| ch_force_off | input | NCH | Per-channel force-off override (wins) |
| sreq_force | input | 1 | Force the combined request asserted |
| sreq_active_high | input | 1 | Combined request sense: 1 = active high |
| sreq_open | input | 1 | 1 = drive only while asserted |
| reg_mode | input | 2 | Regulator mode code |
| thermal_fault | input | 1 | Over-temperature shutdown flag |
| ch_enable | output | NCH | Registered channel clock enables |
| sreq_level | output | 1 | Combined request pin level |
| sreq_drive_en | output | 1 | Combined request output enable |
| reg_enable | output | 1 | Regulator enable |
| stat_ch_req | output | NCH | Status: qualified channel requests |
| stat_sreq | output | 1 | Status: combined request asserted |

## Verification
The properties assume that configuration and fault inputs change only between clock edges, as register outputs would. They also assume that each value is held for at least one cycle, so a one-cycle look back is enough to relate a setting to the registered outputs. The request pins are treated as asynchronous and are never referenced directly in a property. The bench follows these assumptions. It changes every input on the falling edge and holds each vector for four cycles before it samples, which is longer than the three-edge pin path.

// File: rtl/clkreq_pkg.sv
`timescale 1ns/1ps
package clkreq_pkg;
  typedef enum logic [1:0] {
    REG_OFF   = 2'b00,
    REG_RSVD  = 2'b01,
    REG_TRACK = 2'b10,
    REG_ON    = 2'b11
  } reg_mode_e;
endpackage

// File: rtl/clkreq_sync.sv
`timescale 1ns/1ps
module clkreq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkreq_qual.sv
`timescale 1ns/1ps
module clkreq_qual (
  input  logic pin_s,
  input  logic active_high,
  input  logic force_on,
  input  logic force_off,
  output logic req
);
  always_comb begin
    if (force_off)     req = 1'b0;
    else if (force_on) req = 1'b1;
    else               req = ~(pin_s ^ active_high);
  end
endmodule

// File: rtl/clkreq_out.sv
`timescale 1ns/1ps
module clkreq_out
  import clkreq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           sreq_force,
  input  logic           sreq_active_high,
  input  logic           sreq_open,
  input  reg_mode_e      mode,
  input  logic           thermal_fault,
  output logic [NCH-1:0] ch_enable,
  output logic           sreq_level,
  output logic           sreq_drive_en,
  output logic           reg_enable,
  output logic [NCH-1:0] stat_ch_req,
  output logic           stat_sreq
);
  logic any_req, asserted, reg_on;

  always_comb begin
    any_req  = |req;
    asserted = ~thermal_fault & (any_req | sreq_force);
    unique case (mode)
      REG_ON:    reg_on = 1'b1;
      REG_TRACK: reg_on = any_req;
      default:   reg_on = 1'b0;
    endcase
    reg_on = reg_on & ~thermal_fault;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_enable     <= '0;
      sreq_level    <= 1'b0;
      sreq_drive_en <= 1'b0;
      reg_enable    <= 1'b0;
      stat_ch_req   <= '0;
      stat_sreq     <= 1'b0;
    end else begin
      ch_enable     <= thermal_fault ? '0 : req;
      sreq_level    <= sreq_active_high ? asserted : ~asserted;
      sreq_drive_en <= sreq_open ? asserted : 1'b1;
      reg_enable    <= reg_on;
      stat_ch_req   <= req;
      stat_sreq     <= asserted;
    end
  end
endmodule

// File: rtl/clkreq_arbiter.sv
`timescale 1ns/1ps
module clkreq_arbiter
  import clkreq_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req_pin,
  input  logic [NCH-1:0] ch_active_high,
  input  logic [NCH-1:0] ch_force_on,
  input  logic [NCH-1:0] ch_force_off,
  input  logic           sreq_force,
  input  logic           sreq_active_high,
  input  logic           sreq_open,
  input  logic [1:0]     reg_mode,
  input  logic           thermal_fault,
  output logic [NCH-1:0] ch_enable,
  output logic           sreq_level,
  output logic           sreq_drive_en,
  output logic           reg_enable,
  output logic [NCH-1:0] stat_ch_req,
  output logic           stat_sreq
);
  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] req;

  clkreq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(req_pin), .q(pin_s)
  );

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      clkreq_qual u_qual (
        .pin_s      (pin_s[i]),
        .active_high(ch_active_high[i]),
        .force_on   (ch_force_on[i]),
        .force_off  (ch_force_off[i]),
        .req        (req[i])
      );
    end
  endgenerate

  clkreq_out #(.NCH(NCH)) u_out (
    .clk             (clk),
    .rst             (rst),
    .req             (req),
    .sreq_force      (sreq_force),
    .sreq_active_high(sreq_active_high),
    .sreq_open       (sreq_open),
    .mode            (reg_mode_e'(reg_mode)),
    .thermal_fault   (thermal_fault),
    .ch_enable       (ch_enable),
    .sreq_level      (sreq_level),
    .sreq_drive_en   (sreq_drive_en),
    .reg_enable      (reg_enable),
    .stat_ch_req     (stat_ch_req),
    .stat_sreq       (stat_sreq)
  );
endmodule

// File: rtl/clkreq_chk.sv
`timescale 1ns/1ps
module clkreq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] req_pin,
  input logic [NCH-1:0] ch_active_high,
  input logic [NCH-1:0] ch_force_on,
  input logic [NCH-1:0] ch_force_off,
  input logic           sreq_force,
  input logic           sreq_active_high,
  input logic           sreq_open,
  input logic [1:0]     reg_mode,
  input logic           thermal_fault,
  input logic [NCH-1:0] ch_enable,
  input logic           sreq_level,
  input logic           sreq_drive_en,
  input logic           reg_enable,
  input logic [NCH-1:0] stat_ch_req,
  input logic           stat_sreq
);
  // R2
  force_off_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_force_off != '0) |=> ((ch_enable & $past(ch_force_off)) == '0));

  // R3
  force_on_chk: assert property (@(posedge clk) disable iff (rst)
    ((ch_force_on & ~ch_force_off) != '0) |=>
      ((stat_ch_req & $past(ch_force_on & ~ch_force_off)) == $past(ch_force_on & ~ch_force_off)));

  // R8
  thermal_off_chk: assert property (@(posedge clk) disable iff (rst)
    thermal_fault |=> (ch_enable == '0 && !reg_enable && !stat_sreq));

  // R6
  open_drive_chk: assert property (@(posedge clk) disable iff (rst)
    sreq_open |=> (sreq_drive_en == stat_sreq));

  // R6
  pushpull_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !sreq_open |=> sreq_drive_en);

  // R5
  level_high_chk: assert property (@(posedge clk) disable iff (rst)
    sreq_active_high |=> (sreq_level == stat_sreq));

  // R5
  level_low_chk: assert property (@(posedge clk) disable iff (rst)
    !sreq_active_high |=> (sreq_level != stat_sreq));

  // R7
  reg_forced_on_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_mode == 2'b11 && !thermal_fault) |=> reg_enable);

  // R7
  reg_off_codes_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_mode[1] |=> !reg_enable);

  // R4
  sreq_force_chk: assert property (@(posedge clk) disable iff (rst)
    (sreq_force && !thermal_fault) |=> stat_sreq);
endmodule

bind clkreq_arbiter clkreq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_clkreq_arbiter.sv
`timescale 1ns/1ps
module sim_clkreq_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req_pin = '0, ch_active_high = 4'hF, ch_force_on = '0, ch_force_off = '0;
  logic       sreq_force = 0, sreq_active_high = 1, sreq_open = 0, thermal_fault = 0;
  logic [1:0] reg_mode = 2'b10;
  logic [3:0] ch_enable, stat_ch_req;
  logic       sreq_level, sreq_drive_en, reg_enable, stat_sreq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  clkreq_arbiter #(.NCH(4), .SYNC_STAGES(2)) u0 (.*);

  typedef struct packed {
    logic [3:0] pin;
    logic [3:0] pol;
    logic [3:0] fon;
    logic [3:0] foff;
    logic       sf;
    logic       sp;
    logic       so;
    logic [1:0] md;
    logic       th;
    logic [3:0] e_en;
    logic       e_lvl;
    logic       e_drv;
    logic       e_reg;
    logic [3:0] e_sts;
    logic       e_ss;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    // R1 idle, no request
    '{4'b0000,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b0000,1'b0,1'b1,1'b0,4'b0000,1'b0},
    // R1 active-high pins
    '{4'b0101,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b0101,1'b1,1'b1,1'b1,4'b0101,1'b1},
    // R1 active-low pins
    '{4'b0101,4'b0000,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b1010,1'b1,1'b1,1'b1,4'b1010,1'b1},
    // R1 active-low, all pins high
    '{4'b1111,4'b0000,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b0000,1'b0,1'b1,1'b0,4'b0000,1'b0},
    // R3 force-on
    '{4'b0000,4'b1111,4'b0011,4'b0000,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b0011,1'b1,1'b1,1'b1,4'b0011,1'b1},
    // R2 force-off over force-on and pin
    '{4'b1111,4'b1111,4'b1111,4'b1111,1'b0,1'b1,1'b0,2'b10,1'b0, 4'b0000,1'b0,1'b1,1'b0,4'b0000,1'b0},
    // R4 forced request, R7 track mode does not follow it
    '{4'b0000,4'b1111,4'b0000,4'b0000,1'b1,1'b1,1'b0,2'b10,1'b0, 4'b0000,1'b1,1'b1,1'b0,4'b0000,1'b1},
    // R5 active-low output asserted
    '{4'b1000,4'b1111,4'b0000,4'b0000,1'b0,1'b0,1'b0,2'b10,1'b0, 4'b1000,1'b0,1'b1,1'b1,4'b1000,1'b1},
    // R6 open-drain idle: released
    '{4'b0000,4'b1111,4'b0000,4'b0000,1'b0,1'b0,1'b1,2'b10,1'b0, 4'b0000,1'b1,1'b0,1'b0,4'b0000,1'b0},
    // R6 open-drain asserted: drives low
    '{4'b0010,4'b1111,4'b0000,4'b0000,1'b0,1'b0,1'b1,2'b10,1'b0, 4'b0010,1'b0,1'b1,1'b1,4'b0010,1'b1},
    // R6 open-source idle
    '{4'b0000,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b1,2'b10,1'b0, 4'b0000,1'b0,1'b0,1'b0,4'b0000,1'b0},
    // R7 mode 11 always on
    '{4'b0000,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b11,1'b0, 4'b0000,1'b0,1'b1,1'b1,4'b0000,1'b0},
    // R7 mode 00 off with requests
    '{4'b1111,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b00,1'b0, 4'b1111,1'b1,1'b1,1'b0,4'b1111,1'b1},
    // R7 reserved 01 behaves as off
    '{4'b1111,4'b1111,4'b0000,4'b0000,1'b0,1'b1,1'b0,2'b01,1'b0, 4'b1111,1'b1,1'b1,1'b0,4'b1111,1'b1},
    // R8 thermal shutdown, R9 status stays live
    '{4'b1111,4'b1111,4'b0000,4'b0000,1'b1,1'b1,1'b0,2'b11,1'b1, 4'b0000,1'b0,1'b1,1'b0,4'b1111,1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input vec_t v);
    chk({tag, " ch_enable"},     {12'd0, ch_enable},     {12'd0, v.e_en});
    chk({tag, " sreq_level"},    {15'd0, sreq_level},    {15'd0, v.e_lvl});
    chk({tag, " sreq_drive_en"}, {15'd0, sreq_drive_en}, {15'd0, v.e_drv});
    chk({tag, " reg_enable"},    {15'd0, reg_enable},    {15'd0, v.e_reg});
    chk({tag, " stat_ch_req R9"},{12'd0, stat_ch_req},   {12'd0, v.e_sts});
    chk({tag, " stat_sreq R9"},  {15'd0, stat_sreq},     {15'd0, v.e_ss});
  endtask

  task automatic drive(input vec_t v);
    req_pin = v.pin; ch_active_high = v.pol; ch_force_on = v.fon; ch_force_off = v.foff;
    sreq_force = v.sf; sreq_active_high = v.sp; sreq_open = v.so; reg_mode = v.md;
    thermal_fault = v.th;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ch_enable",  {12'd0, ch_enable}, 16'd0);
    chk("R11 sreq pins",  {14'd0, sreq_level, sreq_drive_en}, 16'd0);
    chk("R11 reg/status", {11'd0, reg_enable, stat_ch_req}, 16'd0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VT[k]);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check_vec($sformatf("vec%0d", k), VT[k]);
    end

    // R10 pin latency: visible on third edge, not second
    drive(VT[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    req_pin = 4'b0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 pin after 2 edges", {12'd0, ch_enable}, 16'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 pin after 3 edges", {12'd0, ch_enable}, 16'd1);

    // R10 config latency: one edge; R2 force-off drops channel 0
    ch_force_off = 4'b0001;
    @(posedge clk);
    @(negedge clk);
    chk("R10 R2 force-off after 1 edge", {12'd0, ch_enable}, 16'd0);
    ch_force_off = 4'b0000;
    @(posedge clk);
    @(negedge clk);
    chk("R10 R1 release after 1 edge", {12'd0, ch_enable}, 16'd1);

    // R8 thermal release restores enables on next edge
    thermal_fault = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 fault gates", {11'd0, ch_enable, stat_sreq}, 16'd0);
    thermal_fault = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 fault released", {11'd0, ch_enable, stat_sreq}, {11'd0, 4'b0001, 1'b1});

    // R11 reset mid-run clears outputs and synchronizer
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 reset clears", {10'd0, ch_enable, stat_sreq, reg_enable}, 16'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 sync cleared", {12'd0, ch_enable}, 16'd0);

    finish_run();
  end
endmodule